// File: doc/BRIEF.md
# Bitfield Extract-and-Place Unit

This execution unit copies a contiguous run of bits out of one source operand and writes it into a second operand at an independent bit offset. The run is `fld_len` bits long and begins at bit `src_pos` of `op_a`. It lands at bit `dst_pos` of the result. Every result bit outside the landed run keeps the value of `op_b` at that position. When `invert` is high, `op_a` is complemented before the run is taken. `op_b` is never complemented.

The datapath width `XLEN` is a parameter and may be 32 or 64. The three position and length inputs are `POS_W` bits wide, 7 by default. Any combination that does not fit in the word is flagged as illegal, and the result is then forced to zero. An optional output register stage is selected with `OUT_REG`. With the register, a request strobed on `in_valid` shows up on the outputs one clock later. Without it, the unit is purely combinational.

Top module: `bfp_unit`

## Requirements
- R1: The result bits `[dst_pos, dst_pos+fld_len-1]` equal `op_a` bits `[src_pos, src_pos+fld_len-1]`, in the same bit order.
- R2: For a legal request, every result bit outside `[dst_pos, dst_pos+fld_len-1]` equals the bit of `op_b` at the same position.
- R3: With `invert` = 1, the placed bits come from the bitwise complement of `op_a`; the bits taken from `op_b` are never complemented.
- R4: `fld_len` = 0 raises `out_illegal`.
- R5: `src_pos + fld_len > XLEN` raises `out_illegal`.
- R6: `dst_pos + fld_len > XLEN` raises `out_illegal`.
- R7: Whenever `out_illegal` is 1, `out_data` is all zeros.
- R8: `fld_len` = XLEN with `src_pos` = `dst_pos` = 0 is legal and returns `op_a` unchanged (or its complement when `invert` = 1), with no mask overflow.
- R9: With `OUT_REG` = 1, the outputs for a request with `in_valid` = 1 appear after exactly one rising clock edge, and `out_valid` equals the `in_valid` of the previous cycle. After reset, `out_valid`, `out_data` and `out_illegal` are all 0.
- R10: With `OUT_REG` = 1, a cycle with `in_valid` = 0 leaves `out_data` and `out_illegal` unchanged, whatever the other inputs are.
- R11: All range checks and the masking use `XLEN`, so R1 to R8 hold both for `XLEN` = 32 and for `XLEN` = 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | XLEN | Operand the field is taken from |
| op_b | input | XLEN | Operand that supplies the bits outside the field |
| src_pos | input | POS_W | Lowest bit of the field in `op_a` |
| fld_len | input | POS_W | Field length in bits |
| dst_pos | input | POS_W | Lowest bit of the field in the result |
| invert | input | 1 | Complement `op_a` before the field is taken |
| out_valid | output | 1 | Result strobe |
| out_data | output | XLEN | Merged result |
| out_illegal | output | 1 | The position and length combination does not fit |

## Verification
The hardest cases to reach are the edges of the legal region: a field that ends exactly on the top bit of the word, a field one bit too long, and a field as long as the whole word. Random position values seldom land on these. The stimulus therefore sweeps every combination of start, length and destination from 0 up to a few values past `XLEN` on a 32-bit instance. The operands are random and the complement bit alternates. A 64-bit instance receives targeted full-width and overflow cases, plus random triples. Each result is compared with a bit-by-bit model.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  localparam int DEF_POS_W = 7;

  // true when a run of len bits starting at pos does not fit in limit bits
  function automatic logic span_exceeds(input int unsigned pos,
                                        input int unsigned len,
                                        input int unsigned limit);
    return (pos + len) > limit;
  endfunction
endpackage

// File: rtl/bfp_range_chk.sv
module bfp_range_chk
  import bfp_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int POS_W = DEF_POS_W
) (
  input  logic [POS_W-1:0] src_pos,
  input  logic [POS_W-1:0] fld_len,
  input  logic [POS_W-1:0] dst_pos,
  output logic             len_zero,
  output logic             src_over,
  output logic             dst_over,
  output logic             illegal
);
  always_comb begin
    len_zero = (fld_len == '0);
    src_over = span_exceeds(int'(src_pos), int'(fld_len), XLEN);
    dst_over = span_exceeds(int'(dst_pos), int'(fld_len), XLEN);
    illegal  = len_zero | src_over | dst_over;
  end
endmodule

// File: rtl/bfp_mask_gen.sv
module bfp_mask_gen #(
  parameter int XLEN  = 64,
  parameter int POS_W = 7
) (
  input  logic [POS_W-1:0] fld_len,
  input  logic [POS_W-1:0] dst_pos,
  output logic [XLEN-1:0]  fld_mask,
  output logic [XLEN-1:0]  place_mask
);
  localparam logic [XLEN:0] ONE_W = {{XLEN{1'b0}}, 1'b1};

  // low n bits set; computed one bit wider so n == XLEN gives all ones
  function automatic logic [XLEN-1:0] low_ones(input logic [POS_W-1:0] n);
    logic [XLEN:0] wide;
    wide = (ONE_W << n) - ONE_W;
    return wide[XLEN-1:0];
  endfunction

  always_comb begin
    fld_mask   = low_ones(fld_len);
    place_mask = fld_mask << dst_pos;
  end
endmodule

// File: rtl/bfp_merge.sv
module bfp_merge #(
  parameter int XLEN  = 64,
  parameter int POS_W = 7
) (
  input  logic [XLEN-1:0]  op_a,
  input  logic [XLEN-1:0]  op_b,
  input  logic [POS_W-1:0] src_pos,
  input  logic [POS_W-1:0] dst_pos,
  input  logic             invert,
  input  logic             illegal,
  input  logic [XLEN-1:0]  fld_mask,
  input  logic [XLEN-1:0]  place_mask,
  output logic [XLEN-1:0]  field_bits,
  output logic [XLEN-1:0]  result
);
  logic [XLEN-1:0] src_word;

  always_comb begin
    src_word   = op_a ^ {XLEN{invert}};
    field_bits = (src_word >> src_pos) & fld_mask;
    if (illegal) result = '0;
    else         result = (op_b & ~place_mask) | (field_bits << dst_pos);
  end
endmodule

// File: rtl/bfp_unit.sv
module bfp_unit
  import bfp_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int POS_W   = DEF_POS_W,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  op_a,
  input  logic [XLEN-1:0]  op_b,
  input  logic [POS_W-1:0] src_pos,
  input  logic [POS_W-1:0] fld_len,
  input  logic [POS_W-1:0] dst_pos,
  input  logic             invert,
  output logic             out_valid,
  output logic [XLEN-1:0]  out_data,
  output logic             out_illegal
);
  logic            len_zero, src_over, dst_over, comb_illegal;
  logic [XLEN-1:0] fld_mask, place_mask, field_bits, comb_result;

  bfp_range_chk #(.XLEN(XLEN), .POS_W(POS_W)) u_range (
    .src_pos (src_pos),
    .fld_len (fld_len),
    .dst_pos (dst_pos),
    .len_zero(len_zero),
    .src_over(src_over),
    .dst_over(dst_over),
    .illegal (comb_illegal)
  );

  bfp_mask_gen #(.XLEN(XLEN), .POS_W(POS_W)) u_mask (
    .fld_len   (fld_len),
    .dst_pos   (dst_pos),
    .fld_mask  (fld_mask),
    .place_mask(place_mask)
  );

  bfp_merge #(.XLEN(XLEN), .POS_W(POS_W)) u_merge (
    .op_a      (op_a),
    .op_b      (op_b),
    .src_pos   (src_pos),
    .dst_pos   (dst_pos),
    .invert    (invert),
    .illegal   (comb_illegal),
    .fld_mask  (fld_mask),
    .place_mask(place_mask),
    .field_bits(field_bits),
    .result    (comb_result)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid   <= 1'b0;
          out_data    <= '0;
          out_illegal <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            out_data    <= comb_result;
            out_illegal <= comb_illegal;
          end
        end
      end
    end else begin : g_comb
      always_comb begin
        out_valid   = in_valid;
        out_data    = comb_result;
        out_illegal = comb_illegal;
      end
    end
  endgenerate
endmodule

// File: rtl/bfp_unit_chk.sv
module bfp_unit_chk #(
  parameter int XLEN    = 64,
  parameter int POS_W   = 7,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [XLEN-1:0]  op_b,
  input logic [POS_W-1:0] fld_len,
  input logic             comb_illegal,
  input logic [XLEN-1:0]  comb_result,
  input logic [XLEN-1:0]  place_mask,
  input logic             out_valid,
  input logic [XLEN-1:0]  out_data,
  input logic             out_illegal
);
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_data == '0));  // R7

  AST_OUTSIDE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !comb_illegal |-> ((comb_result & ~place_mask) == (op_b & ~place_mask)));  // R2

  AST_LEN_ZERO_COMB: assert property (@(posedge clk) disable iff (!rst_n)
    (fld_len == '0) |-> comb_illegal);  // R4

  generate
    if (OUT_REG) begin : g_reg_chk
      AST_LEN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fld_len == '0) |=> (out_valid && out_illegal));  // R4

      AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R9

      AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);  // R9

      AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_illegal)));  // R10
    end
  endgenerate
endmodule

bind bfp_unit bfp_unit_chk #(.XLEN(XLEN), .POS_W(POS_W), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .op_b        (op_b),
  .fld_len     (fld_len),
  .comb_illegal(comb_illegal),
  .comb_result (comb_result),
  .place_mask  (place_mask),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/bfp_unit_bench.sv
`timescale 1ns/1ps
module bfp_unit_bench;
  localparam real CLK_P = 20.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // 32-bit instance
  logic        v32 = 1'b0, c32 = 1'b0;
  logic [31:0] a32 = '0, b32 = '0;
  logic [6:0]  s32 = '0, l32 = '0, d32 = '0;
  logic        ov32, il32;
  logic [31:0] od32;

  bfp_unit #(.XLEN(32), .POS_W(7), .OUT_REG(1'b1)) u_bfp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(v32), .op_a(a32), .op_b(b32),
    .src_pos(s32), .fld_len(l32), .dst_pos(d32), .invert(c32),
    .out_valid(ov32), .out_data(od32), .out_illegal(il32)
  );

  // 64-bit instance
  logic        v64 = 1'b0, c64 = 1'b0;
  logic [63:0] a64 = '0, b64 = '0;
  logic [6:0]  s64 = '0, l64 = '0, d64 = '0;
  logic        ov64, il64;
  logic [63:0] od64;

  bfp_unit #(.XLEN(64), .POS_W(7), .OUT_REG(1'b1)) u_bfp_unit_w64 (
    .clk(clk), .rst_n(rst_n), .in_valid(v64), .op_a(a64), .op_b(b64),
    .src_pos(s64), .fld_len(l64), .dst_pos(d64), .invert(c64),
    .out_valid(ov64), .out_data(od64), .out_illegal(il64)
  );

  function automatic bit ref_bad(int xl, int s, int l, int d);
    return (l == 0) || (s + l > xl) || (d + l > xl);
  endfunction

  // bit-by-bit reference
  function automatic logic [63:0] ref_val(int xl, logic [63:0] a, logic [63:0] b,
                                          int s, int l, int d, logic c);
    logic [63:0] r;
    r = '0;
    if (ref_bad(xl, s, l, d)) return r;
    for (int i = 0; i < xl; i++) begin
      if (i >= d && i < d + l) r[i] = a[s + i - d] ^ c;
      else                     r[i] = b[i];
    end
    return r;
  endfunction

  function automatic string tag_of(int xl, int s, int l, int d, logic c);
    if (l == 0)      return "R4";
    if (s + l > xl)  return "R5";
    if (d + l > xl)  return "R6";
    if (l == xl)     return "R8";
    if (c)           return "R3";
    return "R1";
  endfunction

  task automatic note(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors <= 30) $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run32(logic [31:0] a, logic [31:0] b, int s, int l, int d, logic c);
    logic [63:0] e;
    bit bad;
    @(negedge clk);
    v32 = 1'b1; a32 = a; b32 = b; s32 = 7'(s); l32 = 7'(l); d32 = 7'(d); c32 = c;
    e = ref_val(32, {32'h0, a}, {32'h0, b}, s, l, d, c);
    bad = ref_bad(32, s, l, d);
    @(posedge clk); #1;
    note(ov32 && (il32 == bad) && (od32 == e[31:0]),
         {tag_of(32, s, l, d, c), bad ? "/R7" : "/R2"},
         {31'h0, il32, od32}, {31'h0, bad, e[31:0]});
  endtask

  task automatic run64(logic [63:0] a, logic [63:0] b, int s, int l, int d, logic c);
    logic [63:0] e;
    bit bad;
    @(negedge clk);
    v64 = 1'b1; a64 = a; b64 = b; s64 = 7'(s); l64 = 7'(l); d64 = 7'(d); c64 = c;
    e = ref_val(64, a, b, s, l, d, c);
    bad = ref_bad(64, s, l, d);
    @(posedge clk); #1;
    note(ov64 && (il64 == bad) && (od64 == e), {"R11/", tag_of(64, s, l, d, c)},
         od64 ^ {63'h0, il64}, e ^ {63'h0, bad});
  endtask

  initial begin
    logic [31:0] held;
    #(CLK_P * 3);
    // R9: reset state
    note(!ov32 && od32 == '0 && !il32, "R9 reset", {31'h0, ov32, od32}, 64'h0);
    note(!ov64 && od64 == '0 && !il64, "R9 reset w64", od64, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2: zero source into all-ones background
    run32(32'h0, 32'hFFFF_FFFF, 4, 8, 12, 1'b0);
    // R3: inverted source, background untouched
    run32(32'h0, 32'h1234_5678, 0, 4, 28, 1'b1);
    // R8: full width, plain and inverted
    run32(32'hDEAD_BEEF, 32'h0, 0, 32, 0, 1'b0);
    run32(32'hDEAD_BEEF, 32'h5555_5555, 0, 32, 0, 1'b1);
    // R5 / R6 one past the edge
    run32(32'hFFFF_FFFF, 32'h0, 31, 2, 0, 1'b0);
    run32(32'hFFFF_FFFF, 32'h0, 0, 2, 31, 1'b0);

    // R9 / R10: idle cycle holds data, valid drops
    run32(32'hA5A5_0F0F, 32'h0, 8, 16, 4, 1'b0);
    held = od32;
    @(negedge clk);
    v32 = 1'b0; a32 = 32'hFFFF_FFFF; l32 = 7'd0; s32 = 7'd3;
    @(posedge clk); #1;
    note(!ov32, "R9 valid drop", {63'h0, ov32}, 64'h0);
    note(od32 == held && !il32, "R10 hold", {31'h0, il32, od32}, {32'h0, held});

    // near-exhaustive sweep on the 32-bit instance
    for (int l = 0; l <= 34; l++)
      for (int s = 0; s <= 34; s++)
        for (int d = 0; d <= 34; d++)
          run32($urandom, $urandom, s, l, d, 1'((l + s + d) & 1));
    @(negedge clk); v32 = 1'b0;

    // 64-bit targeted and random
    run64({$urandom, $urandom}, 64'h0, 0, 64, 0, 1'b0);
    run64({$urandom, $urandom}, {$urandom, $urandom}, 0, 64, 0, 1'b1);
    run64(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32, 32, 0, 1'b0);
    run64(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 33, 32, 0, 1'b0);
    run64(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, 32, 33, 1'b0);
    run64(64'h1, 64'h0, 0, 1, 63, 1'b0);
    run64(64'h1, 64'h0, 0, 0, 5, 1'b0);
    for (int k = 0; k < 3000; k++)
      run64({$urandom, $urandom}, {$urandom, $urandom},
            int'($urandom_range(0, 66)), int'($urandom_range(0, 66)),
            int'($urandom_range(0, 66)), 1'($urandom));
    @(negedge clk); v64 = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule